// File: doc/BRIEF.md
# Capture Timestamp FIFO

This block buffers timer values taken by one input-capture channel until software collects them. Each capture strobe carries a timer word. The block keeps a small first-in first-out store of those words. A reader sees the oldest stored word on the read port and removes it by pulsing the read strobe. Edge detection, the timer itself and interrupt counting are handled elsewhere. This block only sees capture strobes and read strobes.

Two flags describe the store. One shows that at least one word is held. The other is a sticky overflow flag. In the normal mode, a capture that arrives while the store is full is discarded and raises the overflow flag. From then on the store refuses every capture until the reader has emptied it completely. A mode input selects every-edge operation. In that mode overflow detection is off, so a capture that finds the store full is simply dropped.

Top module: `cap_fifo`

## Requirements
- R1: With default parameters the store holds four words of 16 bits each, and four captures written in a row read back in arrival order.
- R2: `nonempty` goes high in the cycle after the first capture is stored. It stays high until the read that removes the last held word, and goes low in the cycle after that read.
- R3: `rd_word` always shows the oldest held word. A read strobe removes that word, and from the next cycle `rd_word` shows the word that arrived after it.
- R4: In normal mode (`every_edge` = 0), a capture that arrives while four words are held and no read is strobed in the same cycle is discarded, and `ovf_sticky` is 1 from the next cycle.
- R5: After an overflow, every capture is ignored until the store is empty. Once the store is empty, the next capture is stored normally.
- R6: With `every_edge` = 1, a capture that arrives at a full store is dropped with no change to `ovf_sticky` and no lockout. A later capture that finds a free slot is stored.
- R7: A read of an empty store removes nothing and leaves the fill level unchanged. While the store is empty, `rd_word` reads 0.
- R8: `ovf_sticky` stays 1 until `ovf_clr` is pulsed or reset is asserted. Reset also empties the store and clears both flags.
- R9: A capture and a read in the same cycle on a non-empty store remove the oldest word and append the new one in that single cycle. This includes a full store, where no overflow results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | Capture strobe, one cycle per captured value |
| cap_time | input | DATA_W | Timer value carried with the capture strobe |
| rd_stb | input | 1 | Read strobe; removes the oldest word |
| rd_word | output | DATA_W | Oldest held word, or 0 when empty |
| nonempty | output | 1 | At least one word is held |
| ovf_sticky | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Pulse to clear the overflow flag |
| every_edge | input | 1 | 1 selects every-edge mode, with overflow detection off |

## Verification
The bench builds the block with its defaults: 16-bit words and a depth of four. With these values the store fills after four strobes, so overflow, lockout and the full-store simultaneous read-and-capture case can each be reached within a handful of cycles. The stored words are chosen with distinct high and low bits, so that a word placed in the wrong slot or a truncated field shows up at the read port.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;
    // Action the control decides on for one cycle
    typedef struct packed {
        logic push;
        logic pop;
    } fifo_op_t;
endpackage

// File: rtl/capfifo_ctrl.sv
module capfifo_ctrl
    import capfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             rd_i,
    input  logic             every_edge_i,
    input  logic             ovf_clr_i,
    output fifo_op_t         op_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             lock;
        logic             ovf;
    } ctrl_t;

    ctrl_t    d, q;
    fifo_op_t op;
    logic     full, empty, room, ovf_evt;

    always_comb begin
        full    = (q.count == CNT_W'(DEPTH));
        empty   = (q.count == '0);
        op.pop  = rd_i && !empty;
        room    = !full || op.pop;
        op.push = cap_i && !q.lock && room;
        ovf_evt = cap_i && !q.lock && !room && !every_edge_i;

        d       = q;
        d.count = q.count + CNT_W'(op.push) - CNT_W'(op.pop);
        if (ovf_clr_i) d.ovf = 1'b0;
        if (ovf_evt)   d.ovf = 1'b1;
        if (ovf_evt)
            d.lock = 1'b1;
        else if (d.count == '0)
            d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign op_o    = op;
    assign count_o = q.count;
    assign ovf_o   = q.ovf;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CNT_W'(DEPTH)); // R1
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.count == '0) |-> !op_o.pop); // R7
    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !rd_i && !every_edge_i && q.count == CNT_W'(DEPTH)) |=> ovf_o); // R4
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |-> !op_o.push); // R5
    AST_EDGE_MODE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && every_edge_i) |=> !ovf_o); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o); // R8
endmodule

// File: rtl/capfifo_store.sv
module capfifo_store
    import capfifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fifo_op_t          op_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] head_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
    } store_t;

    store_t                       d, q;
    logic [DEPTH-1:0][DATA_W-1:0] slot_nxt;
    logic [CNT_W-1:0]             wr_idx;

    assign wr_idx = count_i - CNT_W'(op_i.pop);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] shifted;
        if (i == DEPTH - 1) begin : g_last
            assign shifted = op_i.pop ? '0 : q.slot[i];
        end else begin : g_mid
            assign shifted = op_i.pop ? q.slot[i+1] : q.slot[i];
        end
        assign slot_nxt[i] = (op_i.push && wr_idx == CNT_W'(i)) ? din_i : shifted;
    end

    always_comb begin
        d      = q;
        d.slot = slot_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_o = (count_i != '0) ? q.slot[0] : '0;

    AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i.pop && !op_i.push && count_i >= CNT_W'(2)) |=> head_o == $past(q.slot[1])); // R3
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo
    import capfifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  logic [DATA_W-1:0] cap_time,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_word,
    output logic              nonempty,
    output logic              ovf_sticky,
    input  logic              ovf_clr,
    input  logic              every_edge
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    fifo_op_t         op;
    logic [CNT_W-1:0] count;

    capfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (cap_stb),
        .rd_i         (rd_stb),
        .every_edge_i (every_edge),
        .ovf_clr_i    (ovf_clr),
        .op_o         (op),
        .count_o      (count),
        .ovf_o        (ovf_sticky)
    );

    capfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .count_i (count),
        .din_i   (cap_time),
        .head_o  (rd_word)
    );

    assign nonempty = (count != '0);

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |-> rd_word == '0); // R7
    AST_FIRST_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonempty && cap_stb && !ovf_sticky) |=> nonempty); // R2
endmodule

// File: tb/tb_cap_fifo.sv
module tb_cap_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_stb = 1'b0;
    logic [15:0] cap_time = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_word;
    logic        nonempty;
    logic        ovf_sticky;
    logic        ovf_clr = 1'b0;
    logic        every_edge = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    cap_fifo dut (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_time(cap_time),
        .rd_stb(rd_stb), .rd_word(rd_word), .nonempty(nonempty),
        .ovf_sticky(ovf_sticky), .ovf_clr(ovf_clr), .every_edge(every_edge)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, release shortly after rising edge
    task automatic step(input logic cap, input logic [15:0] val, input logic rd, input logic clr);
        @(negedge clk);
        cap_stb = cap; cap_time = val; rd_stb = rd; ovf_clr = clr;
        @(posedge clk);
        #2;
        cap_stb = 1'b0; rd_stb = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic put(input logic [15:0] v);
        step(1'b1, v, 1'b0, 1'b0);
    endtask

    task automatic take(input string tag, input logic [15:0] exp);
        check(tag, rd_word, exp);
        step(1'b0, '0, 1'b1, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R8 reset nonempty", 16'(nonempty), 16'd0);
        check("R8 reset ovf", 16'(ovf_sticky), 16'd0);
        check("R7 reset rd_word", rd_word, 16'h0000);
    endtask

    task automatic t_order();
        put(16'hA001);
        check("R2 nonempty after first", 16'(nonempty), 16'd1);
        put(16'h5A02); put(16'hA503); put(16'hFFFF);
        take("R1 word0", 16'hA001);
        take("R3 word1", 16'h5A02);
        take("R3 word2", 16'hA503);
        check("R2 still nonempty", 16'(nonempty), 16'd1);
        take("R1 word3", 16'hFFFF);
        check("R2 empty after drain", 16'(nonempty), 16'd0);
    endtask

    task automatic t_empty_read();
        step(1'b0, '0, 1'b1, 1'b0);
        check("R7 empty read zero", rd_word, 16'h0000);
        check("R7 still empty", 16'(nonempty), 16'd0);
        put(16'h1234);
        take("R7 single entry", 16'h1234);
        check("R7 count unchanged by empty read", 16'(nonempty), 16'd0);
    endtask

    task automatic t_overflow();
        put(16'hB001); put(16'hB002); put(16'hB003); put(16'hB004);
        check("R4 no ovf when just full", 16'(ovf_sticky), 16'd0);
        put(16'hB005);
        check("R4 ovf set", 16'(ovf_sticky), 16'd1);
        take("R4 head kept", 16'hB001);
        put(16'hB006);
        take("R5 locked w2", 16'hB002);
        take("R5 locked w3", 16'hB003);
        take("R5 locked w4", 16'hB004);
        check("R5 capture in lockout dropped", 16'(nonempty), 16'd0);
        put(16'hB007);
        check("R5 accept after drain", rd_word, 16'hB007);
        check("R8 ovf sticky", 16'(ovf_sticky), 16'd1);
        step(1'b0, '0, 1'b0, 1'b1);
        check("R8 ovf cleared", 16'(ovf_sticky), 16'd0);
        take("R5 drained", 16'hB007);
    endtask

    task automatic t_every_edge();
        every_edge = 1'b1;
        put(16'hC001); put(16'hC002); put(16'hC003); put(16'hC004);
        put(16'hC005);
        check("R6 no ovf flag", 16'(ovf_sticky), 16'd0);
        take("R6 head", 16'hC001);
        put(16'hC006);
        take("R6 w2", 16'hC002);
        take("R6 w3", 16'hC003);
        take("R6 w4", 16'hC004);
        take("R6 no lockout", 16'hC006);
        check("R6 empty", 16'(nonempty), 16'd0);
        every_edge = 1'b0;
    endtask

    task automatic t_simultaneous();
        put(16'hD001); put(16'hD002);
        step(1'b1, 16'hD003, 1'b1, 1'b0);
        check("R9 pop and push head", rd_word, 16'hD002);
        put(16'hD004); put(16'hD005);
        step(1'b1, 16'hD006, 1'b1, 1'b0);
        check("R9 full swap no ovf", 16'(ovf_sticky), 16'd0);
        take("R9 w1", 16'hD003);
        take("R9 w2", 16'hD004);
        take("R9 w3", 16'hD005);
        take("R9 new word", 16'hD006);
        check("R9 empty", 16'(nonempty), 16'd0);
    endtask

    task automatic t_reset_empties();
        put(16'hE001); put(16'hE002); put(16'hE003); put(16'hE004); put(16'hE005);
        check("R8 ovf before reset", 16'(ovf_sticky), 16'd1);
        do_reset();
        check("R8 reset empties", 16'(nonempty), 16'd0);
        check("R8 reset clears ovf", 16'(ovf_sticky), 16'd0);
        put(16'hE006);
        take("R8 accepts after reset", 16'hE006);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_overflow();
        t_every_edge();
        t_simultaneous();
        t_reset_empties();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule